// File: doc/BRIEF.md
# Pipelined-Feedback Second-Order IIR Filter

This block filters a stream of signed fixed-point samples with a second-order recursive filter whose denominator has been rewritten so that the recursion only reaches back LA and 2·LA samples. The original pole pair is replaced by the pole pair raised to the power LA. An enlarged numerator of 2·LA+1 taps supplies the zeros that cancel the extra poles, so the overall response matches the original biquad. Because no feedback term uses the previous LA−1 outputs, the feedback multipliers sit outside the one-cycle loop: they work on stored history, and the loop itself is only an adder, a rounder and a clamp. Each pole of the new denominator has a magnitude equal to the original pole magnitude raised to the power LA, so a stable biquad stays stable.

Samples enter one per cycle, qualified by a valid strobe; the delay lines are indexed by accepted sample and not by clock cycle, so idle cycles do not disturb the filter. Each accepted sample produces one output exactly two cycles later. All coefficients are elaboration-time parameters computed off-line. The defaults implement the biquad y[n] = 0.25·x[n] + 0.5·x[n−1] + 0.25·x[n−2] + 0.5·y[n−1] − 0.25·y[n−2] transformed with LA = 2.

Top module: `iir_scattered_la`

## Requirements
- R1: Each accepted sample x[n] yields y[n] = Σ_{k=0..2·LA} NUM_C[k]·x[n−k] + FB_C1·y[n−LA] + FB_C2·y[n−2·LA], where index n counts accepted samples and every term before the last reset is zero; defaults for LA = 2 are NUM_C = {4096, 10240, 9216, 4096, 1024}, FB_C1 = −4096 and FB_C2 = −1024.
- R2: Inputs and outputs are 16-bit two's complement with 15 fraction bits; coefficients are 16-bit two's complement with 14 fraction bits; the full-precision sum is rounded by adding 2^13 and then arithmetic-shifting right by 14.
- R3: A rounded result above 32767 is output as 32767 and one below −32768 as −32768; the clamped value is what is stored in the feedback history.
- R4: `out_valid` is high in exactly the cycle two clock edges after a cycle in which `in_valid` was high and reset was low, and never otherwise.
- R5: A cycle with `in_valid` low neither shifts the delay lines nor affects any later output, whatever `in_data` carries.
- R6: `out_data` keeps its value in every cycle in which `out_valid` is low, apart from being cleared by reset.
- R7: A synchronous reset drives `out_valid` and `out_data` to zero at the next edge, discards samples in flight, and clears all input and output history so the following samples are filtered as if preceded by zeros.
- R8: With the default coefficients and an unclamped output, `out_data` stays within 3 LSB of the exact output of the original biquad with taps 0.25, 0.5, 0.25 and feedback 0.5, −0.25.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_data` in this cycle |
| in_data | input | 16 | Input sample, Q1.15 |
| out_valid | output | 1 | Qualifies `out_data` in this cycle |
| out_data | output | 16 | Filtered sample, Q1.15, clamped |

## Verification
The hardest situation is a feedback term whose source output was produced at a different cycle distance than usual. The multipliers read history that was shifted on the previous cycle, so the tap selection must stay correct whether the preceding output came one cycle earlier or many cycles earlier. The stimulus therefore runs a long stretch with a pseudo-random valid pattern. That pattern mixes back-to-back samples with gaps of several cycles, and garbage is driven on `in_data` during the gaps. Every output is compared bit for bit with a sample-indexed model. A full-scale section then drives the loop into clamping in both directions, so the clamped value is what re-enters the recursion.

// File: rtl/iir_la_pkg.sv
package iir_la_pkg;
    localparam int SAMPLE_W  = 16;
    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 14;
    localparam int PROD_W    = SAMPLE_W + COEF_W;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
    typedef logic signed [PROD_W-1:0]   prod_t;
endpackage

// File: rtl/la_num_fir.sv
module la_num_fir
    import iir_la_pkg::*;
#(
    parameter int    LA    = 2,
    parameter int    ACC_W = PROD_W + $clog2(2*LA+3),
    parameter coef_t NUM_C [2*LA+1] = '{16'sd4096, 16'sd10240, 16'sd9216, 16'sd4096, 16'sd1024}
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  sample_t                 in_data,
    output logic                    num_valid,
    output logic signed [ACC_W-1:0] num_sum
);
    localparam int DEPTH = 2 * LA;

    typedef struct packed {
        sample_t [DEPTH-1:0]     line;
        logic signed [ACC_W-1:0] sum;
        logic                    vld;
    } fir_st_t;

    fir_st_t st_d, st_q;

    always_comb begin
        logic signed [ACC_W-1:0] acc;
        prod_t                   p;
        st_d     = st_q;
        st_d.vld = in_valid;
        p        = NUM_C[0] * in_data;
        acc      = ACC_W'(p);
        for (int k = 1; k <= DEPTH; k++) begin
            p   = NUM_C[k] * $signed(st_q.line[k-1]);
            acc = acc + ACC_W'(p);
        end
        if (in_valid) begin
            st_d.sum     = acc;
            st_d.line[0] = in_data;
            for (int k = 1; k < DEPTH; k++) begin
                st_d.line[k] = st_q.line[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign num_valid = st_q.vld;
    assign num_sum   = st_q.sum;

    // R5: an idle input cycle leaves the partial sum untouched
    p_idle_keep_r5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(num_sum));
endmodule

// File: rtl/la_fb_loop.sv
module la_fb_loop
    import iir_la_pkg::*;
#(
    parameter int    LA    = 2,
    parameter int    ACC_W = PROD_W + $clog2(2*LA+3),
    parameter coef_t FB_C1 = -16'sd4096,
    parameter coef_t FB_C2 = -16'sd1024
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    num_valid,
    input  logic signed [ACC_W-1:0] num_sum,
    output logic                    out_valid,
    output sample_t                 out_data
);
    localparam int HIST = 2 * LA;
    localparam logic signed [ACC_W-1:0] ROUND_HALF = ACC_W'(2 ** (COEF_FRAC - 1));
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(2 ** (SAMPLE_W - 1) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

    typedef struct packed {
        sample_t [HIST-1:0] hist;
        prod_t              fb1;
        prod_t              fb2;
        sample_t            y;
        logic               vld;
    } loop_st_t;

    loop_st_t st_d, st_q;

    always_comb begin
        logic signed [ACC_W-1:0] total;
        logic signed [ACC_W-1:0] shifted;
        sample_t                 y_new;
        st_d     = st_q;
        st_d.vld = num_valid;
        total    = num_sum + ACC_W'(st_q.fb1) + ACC_W'(st_q.fb2) + ROUND_HALF;
        shifted  = total >>> COEF_FRAC;
        if (shifted > SAT_HI)      y_new = SAT_HI[SAMPLE_W-1:0];
        else if (shifted < SAT_LO) y_new = SAT_LO[SAMPLE_W-1:0];
        else                       y_new = shifted[SAMPLE_W-1:0];
        if (num_valid) begin
            st_d.y       = y_new;
            st_d.hist[0] = y_new;
            for (int k = 1; k < HIST; k++) begin
                st_d.hist[k] = st_q.hist[k-1];
            end
        end
        // for LA >= 2 these taps come from registers, not from y_new
        st_d.fb1 = FB_C1 * $signed(st_d.hist[LA-1]);
        st_d.fb2 = FB_C2 * $signed(st_d.hist[HIST-1]);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.y;

    // R6: output data is held while no new result is flagged
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> $stable(out_data));

    // R7: the cycle after reset shows a cleared output
    p_reset_clear_r7: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_data == '0));
endmodule

// File: rtl/iir_scattered_la.sv
module iir_scattered_la
    import iir_la_pkg::*;
#(
    parameter int    LA    = 2,
    parameter coef_t NUM_C [2*LA+1] = '{16'sd4096, 16'sd10240, 16'sd9216, 16'sd4096, 16'sd1024},
    parameter coef_t FB_C1 = -16'sd4096,
    parameter coef_t FB_C2 = -16'sd1024
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_data,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_data
);
    localparam int ACC_W   = PROD_W + $clog2(2*LA+3);
    localparam int LATENCY = 2;

    logic                    num_valid;
    logic signed [ACC_W-1:0] num_sum;

    la_num_fir #(
        .LA    (LA),
        .ACC_W (ACC_W),
        .NUM_C (NUM_C)
    ) u_num (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .num_valid (num_valid),
        .num_sum   (num_sum)
    );

    la_fb_loop #(
        .LA    (LA),
        .ACC_W (ACC_W),
        .FB_C1 (FB_C1),
        .FB_C2 (FB_C2)
    ) u_loop (
        .clk       (clk),
        .rst       (rst),
        .num_valid (num_valid),
        .num_sum   (num_sum),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R4: an accepted sample always emerges LATENCY (=2) edges later
    p_latency_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid, 2) && !$past(rst, 2) && !$past(rst, 1)) |-> out_valid);

    // R4: no output without a matching accepted sample
    p_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));
endmodule

// File: tb/test_iir_scattered_la.sv
module test_iir_scattered_la;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst = 1'b1;
    logic               iv  = 1'b0;
    logic signed [15:0] id  = '0;
    logic               ov;
    logic signed [15:0] od;

    iir_scattered_la i_iir_scattered_la (
        .clk(clk), .rst(rst), .in_valid(iv), .in_data(id),
        .out_valid(ov), .out_data(od)
    );

    int checks = 0;
    int fails  = 0;
    int sat_hi_hits = 0;
    int sat_lo_hits = 0;

    // sample-indexed reference state
    longint xh [0:3];
    longint yh [0:3];
    real    rx1, rx2, ry1, ry2;

    // in-flight expectations: 1 = driven last step, 2 = due now
    logic   pv1 = 0, pv2 = 0;
    longint py1 = 0, py2 = 0;
    real    pr1 = 0.0, pr2 = 0.0;
    logic   pe1 = 0, pe2 = 0;
    longint held = 0;
    logic   after_rst = 1;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 4; k++) begin xh[k] = 0; yh[k] = 0; end
        rx1 = 0.0; rx2 = 0.0; ry1 = 0.0; ry2 = 0.0;
    endtask

    // R1/R2/R3 transformed equation, behavioural
    function automatic longint model_step(input longint x);
        longint acc, y;
        acc = 4096*x + 10240*xh[0] + 9216*xh[1] + 4096*xh[2] + 1024*xh[3]
              - 4096*yh[1] - 1024*yh[3];
        y = (acc + 8192) >>> 14;
        if (y > 32767)  y = 32767;
        if (y < -32768) y = -32768;
        for (int k = 3; k > 0; k--) begin xh[k] = xh[k-1]; yh[k] = yh[k-1]; end
        xh[0] = x; yh[0] = y;
        return y;
    endfunction

    // R8 original biquad in real arithmetic
    function automatic real base_step(input real x);
        real y;
        y = 0.25*x + 0.5*rx1 + 0.25*rx2 + 0.5*ry1 - 0.25*ry2;
        rx2 = rx1; rx1 = x; ry2 = ry1; ry1 = y;
        return y;
    endfunction

    task automatic step(input logic r, input logic v, input longint x, input logic r8);
        real    diff;
        longint ye;
        real    yr;
        @(negedge clk);
        chk(after_rst ? "R7 valid after reset" : "R4 valid timing", longint'(ov), longint'(pv2));
        if (pv2) begin
            chk("R1 R2 data", longint'(od), py2);
            held = py2;
            if (od == 16'sh7fff) sat_hi_hits++;
            if (od == 16'sh8000) sat_lo_hits++;
            if (pe2) begin
                diff = real'(od) - pr2;
                if (diff < 0.0) diff = -diff;
                chk("R8 base response within 3 LSB", longint'(diff <= 3.0), 1);
            end
        end else begin
            chk(after_rst ? "R7 data cleared" : "R6 data held", longint'(od), held);
        end
        after_rst = 0;
        pv2 = pv1; py2 = py1; pr2 = pr1; pe2 = pe1;
        rst = r; iv = v; id = 16'(x);
        if (r) begin
            pv2 = 0; pv1 = 0; pe1 = 0; held = 0; after_rst = 1;
            model_clear();
        end else if (v) begin
            ye = model_step(x);
            yr = base_step(real'(x));
            pv1 = 1; py1 = ye; pr1 = yr; pe1 = r8;
        end else begin
            pv1 = 0; pe1 = 0;
        end
    endtask

    logic done = 0;

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int lfsr;
        model_clear();
        // reset state (R7)
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0);
        // impulse response (R1, R2, R8)
        step(0, 1, 16384, 1);
        for (int i = 0; i < 20; i++) step(0, 1, 0, 1);
        // step input (R1, R8)
        for (int i = 0; i < 30; i++) step(0, 1, 8000, 1);
        // irregular valid with garbage during gaps (R5, R6, R8)
        lfsr = 32'h1d2c;
        for (int i = 0; i < 400; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'h0000b400 : 0);
            if ((lfsr & 3) != 0)
                step(0, 1, longint'(lfsr % 12001) - 6000, 1);
            else
                step(0, 0, longint'(lfsr & 16'h7fff) - 16384, 1);
        end
        // full-scale drive into clamping (R3)
        for (int i = 0; i < 40; i++) step(0, 1, 32767, 0);
        for (int i = 0; i < 40; i++) step(0, 1, -32768, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
        chk("R3 upper clamp reached", longint'(sat_hi_hits > 0), 1);
        chk("R3 lower clamp reached", longint'(sat_lo_hits > 0), 1);
        // reset while samples are in flight (R7)
        for (int i = 0; i < 6; i++) step(0, 1, 20000, 0);
        step(1, 1, 12345, 0);
        step(1, 1, -12345, 0);
        // fresh impulse must match a zero history (R7, R1)
        step(0, 1, -16384, 1);
        for (int i = 0; i < 16; i++) step(0, 1, 0, 1);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule